// File: doc/BRIEF.md
# Seeded Serial Stream Scrambler

This block whitens the serial bit stream of a 100 Mb/s twisted-pair transmitter before line coding. Each symbol clock it may take one NRZ bit from the upstream code-group serializer. It XORs that bit with one keystream bit from an 11-bit closed-loop linear feedback shift register and presents the scrambled bit to the NRZI encoder that follows. The result is a stream with no long repetitive patterns, which lowers peaks in the radiated spectrum.

The register's starting state is built from the device's 5-bit address. This means two transmitters sharing a cable start at different points of the same maximal-length sequence. A registered copy of the keystream bit used in each step is brought out for debug.

Top module: `seeded_scrambler`

## Requirements
- R1: While `rst_n` is low at a rising edge, `dout` and `ks_tap` are cleared to 0. They stay 0 until the first edge at which `bit_vld` is high.
- R2: After reset, the first 11 keystream bits seen on `ks_tap` are the seed, most significant bit first. The seed is the 6-bit constant 100101 (binary) in bits 10..5 and `dev_addr` in bits 4..0, captured while reset is low.
- R3: At an edge where `bit_vld` is high, `dout` takes `din` XOR the keystream bit, which is LFSR bit 10. The same keystream bit appears on `ks_tap` at that edge, so the latency from input to output is one clock.
- R4: At an edge where `bit_vld` is high, the LFSR shifts toward bit 10. The new bit 0 is the old bit 10 XOR the old bit 8, which is the polynomial x^11 + x^9 + 1.
- R5: At an edge where `bit_vld` is low, `dout`, `ks_tap` and the LFSR state hold. `din` has no effect, and the keystream continues from where it stopped.
- R6: The LFSR state is never all zeros, including when `dev_addr` is 0.
- R7: XORing `dout` with a keystream from an identically seeded LFSR, advanced on the same valid cycles, recovers `din` exactly.
- R8: Two different addresses give keystreams that differ within the first 11 bits after reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 125 MHz symbol clock |
| rst_n | input | 1 | Synchronous active-low reset; loads the seed |
| bit_vld | input | 1 | Serial input bit is valid this cycle |
| din | input | 1 | Serial NRZ data bit from the serializer |
| dev_addr | input | 5 | Device address used to build the seed |
| dout | output | 1 | Registered scrambled bit to the NRZI encoder |
| ks_tap | output | 1 | Registered keystream bit used for the last valid step |

## Verification
Two functions can fall in the same cycle: the LFSR shift that produces the keystream, and the output mix that consumes the current keystream bit. The mix must use the bit from before the shift, never the one after. The bench drives long random runs with `bit_vld` toggling every few cycles, so that a shift, a hold and a mix occur back to back. It compares each output against a bench model advanced only on valid cycles. A reset in the middle of a stream, with a new address, checks that the seed load takes priority over a valid bit arriving in the same cycle.

// File: rtl/scr_pkg.sv
// Package: constants shared by the scrambler blocks.
// Assumes the seed is split into a fixed upper pattern and the address.
package scr_pkg;
    localparam int LFSR_W  = 11;
    localparam int ADDR_W  = 5;
    localparam int TAP_HI  = 10;   // output and feedback tap (x^11)
    localparam int TAP_LO  = 8;    // second feedback tap (x^9)
    localparam int UPPER_W = LFSR_W - ADDR_W;
    localparam logic [UPPER_W-1:0] SEED_UPPER = 6'b100101;
endpackage

// File: rtl/scr_seed_map.sv
// Seed map: builds the LFSR start state from the device address.
// Assumes UPPER_PAT is nonzero so the seed can never be all zeros.
module scr_seed_map #(
    parameter int LFSR_W  = scr_pkg::LFSR_W,
    parameter int ADDR_W  = scr_pkg::ADDR_W,
    parameter logic [LFSR_W-ADDR_W-1:0] UPPER_PAT = scr_pkg::SEED_UPPER
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [LFSR_W-1:0] seed
);
    localparam int UW = LFSR_W - ADDR_W;

    generate
        if (UW > 0) begin : g_split
            // Concatenate the fixed upper pattern with the address.
            always_comb seed = {UPPER_PAT, addr};
        end else begin : g_addr_only
            // Address fills the register; force bit 0 so the seed stays nonzero.
            always_comb seed = addr[LFSR_W-1:0] | {{(LFSR_W-1){1'b0}}, 1'b1};
        end
    endgenerate
endmodule

// File: rtl/scr_keystream.sv
// Keystream generator: closed-loop Fibonacci LFSR.
// Loads the seed while reset is low and shifts once per enabled clock.
// Assumes the seed is nonzero; the key bit is the top state bit before the shift.
module scr_keystream #(
    parameter int LFSR_W = scr_pkg::LFSR_W,
    parameter int TAP_HI = scr_pkg::TAP_HI,
    parameter int TAP_LO = scr_pkg::TAP_LO
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              adv,
    input  logic [LFSR_W-1:0] seed,
    output logic              key_bit,
    output logic [LFSR_W-1:0] state
);
    logic fb;

    // Feedback from the two polynomial taps.
    always_comb fb = state[TAP_HI] ^ state[TAP_LO];

    // Output tap is the top state bit.
    always_comb key_bit = state[TAP_HI];

    // State register: seed on reset, shift on advance, hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)
            state <= seed;
        else if (adv)
            state <= {state[LFSR_W-2:0], fb};
    end
endmodule

// File: rtl/scr_mix_reg.sv
// Mix register: XORs the data bit with the key bit and registers both.
// Assumes the key bit is presented in the same cycle as the data.
module scr_mix_reg (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic data_bit,
    input  logic key_bit,
    output logic mix_q,
    output logic key_q
);
    // Output registers: clear on reset, update on enable, else hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mix_q <= 1'b0;
            key_q <= 1'b0;
        end else if (en) begin
            mix_q <= data_bit ^ key_bit;
            key_q <= key_bit;
        end
    end
endmodule

// File: rtl/seeded_scrambler.sv
// Top: bit-serial transmit scrambler with an address-derived seed.
// Assumes one input bit per symbol clock, qualified by bit_vld.
// The address is sampled while reset is low.
module seeded_scrambler (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       bit_vld,
    input  logic                       din,
    input  logic [scr_pkg::ADDR_W-1:0] dev_addr,
    output logic                       dout,
    output logic                       ks_tap
);
    localparam int W = scr_pkg::LFSR_W;

    logic [W-1:0] seed_w;
    logic [W-1:0] lfsr_state;
    logic         key_w;

    scr_seed_map u_seed (
        .addr (dev_addr),
        .seed (seed_w)
    );

    scr_keystream u_ks (
        .clk     (clk),
        .rst_n   (rst_n),
        .adv     (bit_vld),
        .seed    (seed_w),
        .key_bit (key_w),
        .state   (lfsr_state)
    );

    scr_mix_reg u_mix (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (bit_vld),
        .data_bit (din),
        .key_bit  (key_w),
        .mix_q    (dout),
        .key_q    (ks_tap)
    );
endmodule

// File: rtl/scr_checker.sv
// Checker: temporal properties of the scrambler, bound to the top.
module scr_checker #(
    parameter int W = scr_pkg::LFSR_W
) (
    input logic         clk,
    input logic         rst_n,
    input logic         bit_vld,
    input logic         din,
    input logic         dout,
    input logic         ks_tap,
    input logic [W-1:0] state
);
    AST_STATE_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        state != '0);  // R6
    AST_MIX_XOR: assert property (@(posedge clk) disable iff (!rst_n)
        bit_vld |=> dout == ($past(din) ^ ks_tap));  // R3
    AST_KEY_FROM_TOP: assert property (@(posedge clk) disable iff (!rst_n)
        bit_vld |=> ks_tap == $past(state[scr_pkg::TAP_HI]));  // R3
    AST_SHIFT_POLY: assert property (@(posedge clk) disable iff (!rst_n)
        bit_vld |=> state[W-1:1] == $past(state[W-2:0]) &&
                    state[0] == ($past(state[scr_pkg::TAP_HI]) ^ $past(state[scr_pkg::TAP_LO])));  // R4
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_vld |=> $stable(dout) && $stable(ks_tap) && $stable(state));  // R5
endmodule

bind seeded_scrambler scr_checker u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .bit_vld (bit_vld),
    .din     (din),
    .dout    (dout),
    .ks_tap  (ks_tap),
    .state   (lfsr_state)
);

// File: tb/seeded_scrambler_test.sv
// Bench: random plus directed stimulus against a bench LFSR model.
module seeded_scrambler_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bit_vld = 1'b0;
    logic       din = 1'b0;
    logic [4:0] dev_addr = 5'd0;
    wire        dout;
    wire        ks_tap;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    logic [10:0] mdl;       // bench model of the keystream register
    logic        exp_dout;
    logic        exp_ks;

    seeded_scrambler uut (
        .clk(clk), .rst_n(rst_n), .bit_vld(bit_vld), .din(din),
        .dev_addr(dev_addr), .dout(dout), .ks_tap(ks_tap)
    );

    always #5 clk = ~clk;

    function automatic logic [10:0] seed_of(input logic [4:0] a);
        return {6'b100101, a};
    endfunction

    function automatic logic [10:0] next_of(input logic [10:0] s);
        return {s[9:0], s[10] ^ s[8]};
    endfunction

    task automatic check(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s: actual=%0b expected=%0b", req, act, exp);
        end
    endtask

    task automatic do_reset(input logic [4:0] a);
        @(negedge clk);
        rst_n = 1'b0; bit_vld = 1'b1; din = 1'b1; dev_addr = a;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1; bit_vld = 1'b0;
        mdl = seed_of(a); exp_dout = 1'b0; exp_ks = 1'b0;
        @(posedge clk); #1;
        check("R1 dout after reset", dout, 1'b0);
        check("R1 ks_tap after reset", ks_tap, 1'b0);
    endtask

    // One cycle: drive at negedge, update model, sample just after posedge.
    task automatic step(input logic v, input logic d, input string req);
        @(negedge clk);
        bit_vld = v; din = d;
        if (v) begin
            exp_dout = d ^ mdl[10];
            exp_ks   = mdl[10];
            mdl      = next_of(mdl);
        end
        @(posedge clk); #1;
        check(req, dout, exp_dout);
        check(req, ks_tap, exp_ks);
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            failures++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5C3A_11E7));

        // R1, R2: reset state and first 11 keystream bits equal the seed, MSB first
        do_reset(5'h13);
        for (int i = 10; i >= 0; i--) begin
            step(1'b1, 1'b0, "R2 seed bit");
            check("R2 ks vs seed", ks_tap, seed_of(5'h13)[i]);
        end

        // R6: zero address still yields a live keystream
        do_reset(5'h00);
        begin
            int ones = 0;
            for (int i = 0; i < 40; i++) begin
                step(1'b1, 1'b0, "R6 zero addr");
                ones += int'(ks_tap);
            end
            checks++;
            if (ones == 0) begin
                failures++;
                $display("FAIL R6: actual=%0d ones expected=nonzero", ones);
            end
        end

        // R8: two addresses differ within the first 11 bits
        begin
            logic [10:0] sa, sb;
            do_reset(5'h0A);
            for (int i = 0; i < 11; i++) begin step(1'b1, 1'b0, "R8 a"); sa[10-i] = ks_tap; end
            do_reset(5'h15);
            for (int i = 0; i < 11; i++) begin step(1'b1, 1'b0, "R8 b"); sb[10-i] = ks_tap; end
            checks++;
            if (sa == sb) begin
                failures++;
                $display("FAIL R8: actual=%h expected!=%h", sb, sa);
            end
        end

        // R5: idle cycles hold outputs while din toggles
        do_reset(5'h07);
        step(1'b1, 1'b1, "R3 directed");
        for (int i = 0; i < 4; i++) step(1'b0, i[0], "R5 hold");
        step(1'b1, 1'b0, "R5 resume");

        // R3, R4, R5, R7: random run with valid gaps
        for (int i = 0; i < 3000; i++) begin
            logic v, d;
            v = ($urandom % 4) != 0;
            d = $urandom % 2;
            step(v, d, v ? "R3 R4 random" : "R5 random idle");
            if (v) check("R7 descramble", dout ^ exp_ks, d);
        end

        // R1, R2: reset mid-stream with a valid bit present reloads the new seed
        do_reset(5'h1F);
        for (int i = 10; i >= 0; i--) begin
            step(1'b1, $urandom % 2, "R2 reseed");
            check("R2 reseed vs seed", ks_tap, seed_of(5'h1F)[i]);
        end

        // R4: full period 2047 returns the keystream to the start
        do_reset(5'h04);
        for (int i = 0; i < 2047 + 11; i++) step(1'b1, 1'b0, "R4 period");
        check("R4 period wrap", mdl == next_of(next_of(next_of(next_of(next_of(next_of(next_of(next_of(next_of(next_of(next_of(seed_of(5'h04)))))))))))), 1'b1);

        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule